// File: doc/BRIEF.md
# LIN Break-Filtering Serial Receiver

This block turns one serial line into 8-bit characters. The line idles high, and low is the dominant level. A 16x oversampling tick from an external baud generator paces all receive activity. Each character has one low start bit, eight data bits sent least significant first, and one high stop bit. Each bit is decided by a three-sample majority vote near its centre.

When the LIN receive enable is set, a break filter runs after any frame whose stop bit is low. It holds back the frame's data until it can tell a real break from an all-zero character sent by a node whose clock is off by up to ±15%. A skewed 0x00 can stay low for as long as 10.35 nominal bit times, and a true break lasts at least 11.05. The filter threshold sits between those two figures, at 168 sample ticks (10.5 bit times). The current low-run length is always on a port, so upper layers can judge the exact break length themselves.

One byte buffer serves both directions. A receive updates it, and a write from the host loads it and pulses a transmit hand-off strobe.

Top module: `lin_break_rx`

## Requirements
- R1: The line idles high. A frame is a low start bit, eight data bits sent LSB first, and a high stop bit, each 16 os_tick periods long. A frame with a high stop bit produces one rx_valid pulse, and the byte appears on buf_data in that same cycle.
- R2: Tick 0 is the first os_tick that samples the line low while the receiver is idle. Each bit value is the majority of the line samples at ticks 7, 8 and 9 of that bit, so a single wrong sample among the three has no effect.
- R3: If the line is high at tick 8 of the start bit, the receiver abandons the frame without any strobe and waits for the next low sample.
- R4: A frame whose stop bit votes low produces one frame_err pulse, issued on the stop bit's tick 9.
- R5: With lin_en low, a frame with a low stop bit is still delivered: rx_valid pulses in the same cycle as frame_err, and a new start is accepted only after the line has been sampled high.
- R6: With lin_en high, a frame with a low stop bit holds back its byte. If the line is sampled high before the low run reaches 168 ticks, rx_valid pulses with that byte on that tick, and brk_det stays low. This covers a run of 167 ticks.
- R7: With lin_en high, if the low run of such a frame reaches 168 ticks, brk_det pulses exactly once and rx_valid never pulses for that frame.
- R8: After a break, or after a framing error with lin_en low, the receiver ignores the low line until one os_tick samples it high. After that single high tick it accepts a new start bit.
- R9: low_len counts consecutive os_tick samples of a low line. It returns to 0 on the tick after a high sample and saturates at 255.
- R10: When wr_en is high, wr_data goes into the buffer, taking priority over a receive in the same cycle, and tx_load pulses one cycle later. Reset does not change the buffer.
- R11: rx_valid, brk_det and frame_err are registered one-cycle pulses. Each appears in the clock cycle right after the os_tick cycle that caused it.
- R12: After reset, all strobes are low, low_len is 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_line | input | 1 | Serial line, low is dominant, already synchronous to clk |
| lin_en | input | 1 | Enables the break filter |
| wr_en | input | 1 | Loads wr_data into the shared buffer |
| wr_data | input | 8 | Byte to hand to the transmitter |
| buf_data | output | 8 | Shared buffer: last byte received or written |
| rx_valid | output | 1 | Pulse: a received byte was placed in buf_data |
| brk_det | output | 1 | Pulse: a break was recognised |
| frame_err | output | 1 | Pulse: a stop bit was sampled low |
| low_len | output | 8 | Current low-run length in os_tick samples |
| tx_load | output | 1 | Pulse one cycle after a host write |

## Verification
The bench runs the following patterns, each aimed at a different behaviour:
- Clean frames with alternating and mixed bit patterns show that bits are assembled in the right order.
- A frame with one corrupted sample in every bit shows that the majority vote, and not a single sample, decides each bit.
- A short low pulse separates a noise spike from a real start.
- All-low runs of 160, 165, 167, 168, 239 and 300 ticks, with the filter on and off, probe the break threshold from both sides. They cover an ordinary framing error, the deferred delivery of a skewed zero byte, the break strobe itself and counter saturation.
- A frame sent one high tick after a break shows that the receiver re-arms.
- Host writes, including one across a reset, check that the buffer is shared and survives reset.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_FRAME,
    RX_HOLD,
    RX_WAITHI
  } rx_state_e;
endpackage

// File: rtl/lin_lowrun_ctr.sv
module lin_lowrun_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             line,
  output logic [CNT_W-1:0] run_q
);
  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (tick) begin
      if (line) begin
        run_q <= '0;
      end else if (run_q != RUN_MAX) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R9
  run_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !line && run_q == RUN_MAX) |=> (run_q == RUN_MAX));
endmodule

// File: rtl/lin_rx_fsm.sv
module lin_rx_fsm
  import lin_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 8,
  parameter int BRK_TICKS = 168
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              lin_en,
  input  logic [CNT_W-1:0]  run,
  output logic              deliver_c,
  output logic [DATA_W-1:0] byte_c,
  output logic              valid_q,
  output logic              brk_q,
  output logic              ferr_q
);
  localparam int PH_W     = $clog2(OVS);
  localparam int BI_W     = $clog2(DATA_W + 2);
  localparam int PH_MID   = OVS / 2;
  localparam logic [PH_W-1:0]  PH_A    = PH_W'(PH_MID - 1);
  localparam logic [PH_W-1:0]  PH_B    = PH_W'(PH_MID);
  localparam logic [PH_W-1:0]  PH_C    = PH_W'(PH_MID + 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OVS - 1);
  localparam logic [BI_W-1:0]  BI_STOP = BI_W'(DATA_W + 1);
  localparam logic [CNT_W:0]   BRK_LIM = (CNT_W + 1)'(BRK_TICKS);

  rx_state_e         st, st_n;
  logic [PH_W-1:0]   ph, ph_n;
  logic [BI_W-1:0]   bi, bi_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic              v_a, v_a_n, v_b, v_b_n, maj;
  logic              brk_n, ferr_n;

  assign maj    = (v_a & v_b) | (v_a & line) | (v_b & line);
  assign byte_c = sh;

  always_comb begin
    st_n = st; ph_n = ph; bi_n = bi; sh_n = sh;
    v_a_n = v_a; v_b_n = v_b;
    deliver_c = 1'b0; brk_n = 1'b0; ferr_n = 1'b0;
    if (tick) begin
      case (st)
        RX_IDLE: if (!line) begin
          st_n = RX_FRAME;
          ph_n = PH_W'(1);
          bi_n = '0;
        end
        RX_FRAME: begin
          if (ph == PH_LAST) begin
            ph_n = '0;
            bi_n = bi + 1'b1;
          end else begin
            ph_n = ph + 1'b1;
          end
          if (ph == PH_A) v_a_n = line;
          if (ph == PH_B) begin
            v_b_n = line;
            if (bi == '0 && line) st_n = RX_IDLE;
          end
          if (ph == PH_C) begin
            if (bi != '0 && bi != BI_STOP) begin
              sh_n = {maj, sh[DATA_W-1:1]};
            end else if (bi == BI_STOP) begin
              if (maj) begin
                deliver_c = 1'b1;
                st_n = RX_IDLE;
              end else begin
                ferr_n = 1'b1;
                if (lin_en) begin
                  st_n = RX_HOLD;
                end else begin
                  deliver_c = 1'b1;
                  st_n = RX_WAITHI;
                end
              end
            end
          end
        end
        RX_HOLD: begin
          if (line) begin
            deliver_c = 1'b1;
            st_n = RX_IDLE;
          end else if ({1'b0, run} + 1'b1 >= BRK_LIM) begin
            brk_n = 1'b1;
            st_n = RX_WAITHI;
          end
        end
        default: if (line) st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE;
      ph <= '0;
      bi <= '0;
      sh <= '0;
      v_a <= 1'b0;
      v_b <= 1'b0;
      valid_q <= 1'b0;
      brk_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      st <= st_n;
      ph <= ph_n;
      bi <= bi_n;
      sh <= sh_n;
      v_a <= v_a_n;
      v_b <= v_b_n;
      valid_q <= deliver_c;
      brk_q <= brk_n;
      ferr_q <= ferr_n;
    end
  end

  // R7
  brk_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(brk_q && valid_q));

  // R11
  strobe_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q || brk_q || ferr_q) |-> $past(tick));

  // R5
  nolin_ferr_chk: assert property (@(posedge clk) disable iff (rst)
    (ferr_q && !$past(lin_en)) |-> valid_q);

  // R8
  waithi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == RX_WAITHI && tick && !line) |=> (st == RX_WAITHI));
endmodule

// File: rtl/lin_data_buf.sv
module lin_data_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_en,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] buf_q,
  output logic              tx_load
);
  always_ff @(posedge clk) begin
    if (wr_en) begin
      buf_q <= wr_data;
    end else if (rx_en) begin
      buf_q <= rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tx_load <= 1'b0;
    else     tx_load <= wr_en;
  end

  // R10
  buf_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rx_en)) |-> $stable(buf_q));

  // R10
  txload_data_chk: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> (buf_q == $past(wr_data)));
endmodule

// File: rtl/lin_break_rx.sv
module lin_break_rx #(
  parameter int OVS          = 16,
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 8,
  parameter int BRK_HALFBITS = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              lin_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] buf_data,
  output logic              rx_valid,
  output logic              brk_det,
  output logic              frame_err,
  output logic [CNT_W-1:0]  low_len,
  output logic              tx_load
);
  localparam int BRK_TICKS = OVS * BRK_HALFBITS / 2;
  localparam logic [CNT_W:0] BRK_LIM = (CNT_W + 1)'(BRK_TICKS);

  logic              deliver;
  logic [DATA_W-1:0] rx_byte;

  lin_lowrun_ctr #(.CNT_W(CNT_W)) u_run (
    .clk   (clk),
    .rst   (rst),
    .tick  (os_tick),
    .line  (rx_line),
    .run_q (low_len)
  );

  lin_rx_fsm #(
    .OVS       (OVS),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .BRK_TICKS (BRK_TICKS)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tick      (os_tick),
    .line      (rx_line),
    .lin_en    (lin_en),
    .run       (low_len),
    .deliver_c (deliver),
    .byte_c    (rx_byte),
    .valid_q   (rx_valid),
    .brk_q     (brk_det),
    .ferr_q    (frame_err)
  );

  lin_data_buf #(.DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rx_en   (deliver),
    .rx_data (rx_byte),
    .buf_q   (buf_data),
    .tx_load (tx_load)
  );

  // R7
  brk_len_chk: assert property (@(posedge clk) disable iff (rst)
    brk_det |-> ({1'b0, low_len} >= BRK_LIM));

  // R9
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (os_tick && rx_line) |=> (low_len == '0));
endmodule

// File: tb/tb_lin_break_rx.sv
module tb_lin_break_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk, rst, os_tick, rx_line, lin_en, wr_en;
  logic [7:0] wr_data, buf_data, low_len;
  logic       rx_valid, brk_det, frame_err, tx_load;

  lin_break_rx dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line),
    .lin_en(lin_en), .wr_en(wr_en), .wr_data(wr_data),
    .buf_data(buf_data), .rx_valid(rx_valid), .brk_det(brk_det),
    .frame_err(frame_err), .low_len(low_len), .tx_load(tx_load)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int nv = 0, nb = 0, nf = 0, sv, sb, sf;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // reference model state
  int         m_st = 0, m_run = 0;
  bit         samp[$];
  logic [7:0] pend = 8'h00, e_buf = 8'h00;
  bit         buf_known = 0;
  bit         e_valid = 0, e_brk = 0, e_ferr = 0, e_tx = 0;

  function automatic bit vote(input int k);
    int s;
    s = int'(samp[16*k+7]) + int'(samp[16*k+8]) + int'(samp[16*k+9]);
    return s >= 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_run = 0;
      e_valid = 0; e_brk = 0; e_ferr = 0; e_tx = 0;
    end else begin
      e_valid = 0; e_brk = 0; e_ferr = 0; e_tx = 0;
      if (os_tick) begin
        int nr;
        int t;
        nr = rx_line ? 0 : ((m_run < 255) ? m_run + 1 : 255);
        case (m_st)
          0: if (!rx_line) begin
            samp.delete();
            samp.push_back(rx_line);
            m_st = 1;
          end
          1: begin
            samp.push_back(rx_line);
            t = samp.size() - 1;
            if (t == 8 && rx_line) m_st = 0;
            else if (t == 153) begin
              for (int k = 1; k <= 8; k++) pend[k-1] = vote(k);
              if (vote(9)) begin
                e_valid = 1; m_st = 0;
              end else begin
                e_ferr = 1;
                if (lin_en) m_st = 2;
                else begin e_valid = 1; m_st = 3; end
              end
            end
          end
          2: if (rx_line) begin
            e_valid = 1; m_st = 0;
          end else if (m_run + 1 >= 168) begin
            e_brk = 1; m_st = 3;
          end
          default: if (rx_line) m_st = 0;
        endcase
        m_run = nr;
      end
      if (e_valid) begin e_buf = pend; buf_known = 1; end
      if (wr_en) begin e_buf = wr_data; buf_known = 1; e_tx = 1; end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(rx_valid == e_valid, "R1 rx_valid", rx_valid, e_valid);
      chk(brk_det == e_brk, "R7 brk_det", brk_det, e_brk);
      chk(frame_err == e_ferr, "R4 frame_err", frame_err, e_ferr);
      chk(int'(low_len) == m_run, "R9 low_len", low_len, m_run);
      chk(tx_load == e_tx, "R10 tx_load", tx_load, e_tx);
      if (buf_known) chk(buf_data == e_buf, "R10 buf_data", buf_data, e_buf);
      if (rx_valid) nv++;
      if (brk_det) nb++;
      if (frame_err) nf++;
    end
  end

  task automatic ticks(input bit lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_line = lvl; os_tick = 1'b1;
      @(negedge clk); os_tick = 1'b0;
      repeat (TICK_DIV - 2) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input bit glitch);
    for (int k = 0; k < 10; k++) begin
      bit v;
      v = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      for (int p = 0; p < 16; p++) ticks(v ^ (glitch && p == 7), 1);
    end
  endtask

  task automatic snap();
    sv = nv; sb = nb; sf = nf;
  endtask

  task automatic expect_counts(input string req, input int dv, input int db, input int df);
    chk(nv - sv == dv, {req, " rx_valid count"}, nv - sv, dv);
    chk(nb - sb == db, {req, " brk_det count"}, nb - sb, db);
    chk(nf - sf == df, {req, " frame_err count"}, nf - sf, df);
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; os_tick = 1'b0; rx_line = 1'b1; lin_en = 1'b0;
    wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!rx_valid && !brk_det && !frame_err, "R12 strobes", {rx_valid, brk_det, frame_err}, 0);
    chk(low_len == 8'd0, "R12 low_len", low_len, 0);
    ticks(1, 4);

    // R1 clean frames, R11 one-cycle pulse
    snap(); send_frame(8'h55, 0); ticks(1, 4);
    expect_counts("R11", 1, 0, 0);
    chk(buf_data == 8'h55, "R1 byte 55", buf_data, 8'h55);
    snap(); send_frame(8'hA3, 0); ticks(1, 4);
    chk(buf_data == 8'hA3, "R1 byte A3", buf_data, 8'hA3);

    // R2 one bad sample per bit
    snap(); send_frame(8'h6E, 1); ticks(1, 4);
    expect_counts("R2", 1, 0, 0);
    chk(buf_data == 8'h6E, "R2 majority byte", buf_data, 8'h6E);

    // R3 short low spike
    snap(); ticks(0, 6); ticks(1, 30);
    expect_counts("R3", 0, 0, 0);

    // R4 R5 all-low frame without filter
    snap(); ticks(0, 160); ticks(1, 20);
    expect_counts("R5", 1, 0, 1);
    chk(buf_data == 8'h00, "R5 byte", buf_data, 0);

    // R10 host write
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h5A;
    @(negedge clk); wr_en = 1'b0;
    chk(tx_load == 1'b1, "R10 tx_load pulse", tx_load, 1);
    chk(buf_data == 8'h5A, "R10 written byte", buf_data, 8'h5A);

    lin_en = 1'b1;
    // ordinary zero byte with good stop
    snap(); send_frame(8'h00, 0); ticks(1, 4);
    expect_counts("R1 zero byte", 1, 0, 0);

    // R6 skewed zero bytes
    host_write(8'hFF);
    snap(); ticks(0, 165); ticks(1, 20);
    expect_counts("R6 165", 1, 0, 1);
    chk(buf_data == 8'h00, "R6 deferred byte", buf_data, 0);
    snap(); ticks(0, 167); ticks(1, 20);
    expect_counts("R6 167", 1, 0, 1);

    // R7 break at threshold and above
    snap(); ticks(0, 168);
    chk(low_len == 8'd168, "R9 len 168", low_len, 168);
    ticks(1, 20);
    expect_counts("R7 168", 0, 1, 1);
    snap(); ticks(0, 239);
    chk(low_len == 8'd239, "R9 len 239", low_len, 239);
    ticks(1, 20);
    expect_counts("R7 239", 0, 1, 1);

    // R9 saturation, R8 rearm after one high tick
    snap(); ticks(0, 300);
    chk(low_len == 8'd255, "R9 saturate", low_len, 255);
    ticks(1, 1);
    chk(low_len == 8'd0, "R9 clear", low_len, 0);
    send_frame(8'h3C, 0); ticks(1, 4);
    expect_counts("R8", 1, 1, 1);
    chk(buf_data == 8'h3C, "R8 byte after break", buf_data, 8'h3C);

    // R5 long low without filter: no break
    lin_en = 1'b0;
    snap(); ticks(0, 200); ticks(1, 20);
    expect_counts("R5 no filter", 1, 0, 1);

    // R10 reset keeps buffer
    host_write(8'hC6);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(buf_data == 8'hC6, "R10 reset keeps buffer", buf_data, 8'hC6);
    chk(low_len == 8'd0, "R12 low_len after reset", low_len, 0);

    ticks(1, 4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule